// File: doc/BRIEF.md
# Isolated Switch Command Frame Serializer

This block sends one complete command frame to an addressed solid-state-relay driver over a two-wire link: a line clock and a data line. A frame begins with a run of reset symbols. Three header fields follow, each sent most significant bit first: a 3-bit page, the 3-bit device address and a 4-bit command. Ten filler ones close the frame. Each logical symbol is a 16-bit waveform pattern taken from a parameter and shifted out MSB first, one pattern bit per slot. A slot lasts `2*DIV_HALF` system clocks, with the line clock low for the first half and high for the second.

During the same transfer the block samples the returning line and builds an 8-bit status byte. Each status bit comes from one filler symbol. A bit reads as one when the line is high at any of four adjacent slot positions within that symbol. A poll frame copies the byte to the status output when it completes. An on frame or an off frame sets or clears a latched output-on flag when it completes.

Top module: `iso_cmd_serializer`

## Requirements
- R1: After an accepted start, the first `PRE_SYMS` (default 8) symbols on the data line are the reset pattern (default 16'h0000). Every symbol is 16 slots long and is sent from pattern bit 15 down to bit 0.
- R2: Each slot lasts `2*DIV_HALF` clocks. The line clock is low for the first `DIV_HALF` clocks of the slot and high for the rest, and the data line holds steady across the slot. The 10 symbols after the preamble carry page[2:0], then address[2:0], then command[3:0], each most significant bit first. A one is sent with the one pattern (default 16'hFFF0) and a zero with the zero pattern (default 16'hF000).
- R3: Exactly ten one-pattern filler symbols follow the command field. `busy_o` stays high for exactly `(PRE_SYMS+20)*16*2*DIV_HALF` clocks per frame.
- R4: A start with `dev_addr_i` greater than 7 is rejected: no frame starts and `busy_o` stays low.
- R5: Status bit 7 down to bit 0 come from symbols `PRE_SYMS+11` to `PRE_SYMS+18`, counted from 0 at the first preamble symbol. A bit is one when `line_in_i` is sampled high in the line-clock-high half of any slot at positions 4 to 7 of that symbol, counted from 0 at the first slot shifted. Those positions carry pattern bits 11 to 8. The line at any other slot, or in any other symbol, has no effect.
- R6: `status_o` changes only when a poll frame ends (page 3'h0, command 4'h1), and it takes the byte gathered in that frame.
- R7: `out_on_o` goes to 1 when an on frame ends (page 3'h0, command 4'h3) and to 0 when an off frame ends (page 3'h0, command 4'h2). Every other frame leaves it unchanged.
- R8: A start that arrives while `busy_o` is high is ignored. It neither alters the frame in flight nor queues another one.
- R9: `done_o` is high for exactly one clock, in the clock after the last slot. `busy_o` falls on the same edge that raises `done_o`.
- R10: While reset is held and after it is released, `busy_o`, `done_o`, `line_clk_o`, `status_o` and `out_on_o` are all zero.
- R11: `line_oe_o` is high exactly while `busy_o` is high, and `line_out_o` is low whenever `line_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send a frame |
| page_i | input | 3 | Page field of the requested frame |
| cmd_i | input | 4 | Command field of the requested frame |
| dev_addr_i | input | 4 | Static device address; values above 7 are refused |
| line_in_i | input | 1 | Returning data line, sampled for the status byte |
| line_clk_o | output | 1 | Link clock, one period per slot |
| line_out_o | output | 1 | Serial data toward the device |
| line_oe_o | output | 1 | Drive enable for the data line |
| busy_o | output | 1 | A frame is being sent |
| done_o | output | 1 | One-clock pulse at the end of a frame |
| status_o | output | 8 | Status byte from the most recent poll frame |
| out_on_o | output | 1 | Latched switch state |

## Verification
The bench sweeps every page and address value and all sixteen command codes. For each frame it compares all 448 captured slots with an arithmetic model, so a field sent in the wrong order or with a bit misplaced shows up directly. For the status byte, the bench acts as the device and raises the line at only one of the four window slots, rotating which one. It also drives the line high at the slots just outside the window and in the filler symbols around it. A design with a window shifted by one slot, or one that reads the wrong symbol, therefore returns a wrong byte. Further cases cover on and off commands sent on a nonzero page, poll frames that must leave the switch flag alone, a start asserted in the middle of a frame, and addresses above 7. A flawed design would wrongly toggle the flag, overwrite the status byte, or start or restart a frame in these cases.

// File: rtl/iso_cmd_pkg.sv
package iso_cmd_pkg;

    localparam int SLOT_W      = 16;
    localparam int FIELD_SYMS  = 10;
    localparam int FILL_SYMS   = 10;
    localparam int STAT_W      = 8;

    // Header fields in send order: page, then address, then command
    typedef struct packed {
        logic [2:0] page;
        logic [2:0] addr;
        logic [3:0] cmd;
    } frame_hdr_t;

    typedef enum logic [1:0] {
        SYM_RST  = 2'd0,
        SYM_ZERO = 2'd1,
        SYM_ONE  = 2'd2
    } sym_kind_t;

    // Logical value of the j-th symbol after the preamble
    function automatic logic sym_value(frame_hdr_t h, int j);
        logic [FIELD_SYMS-1:0] f;
        logic [FIELD_SYMS-1:0] f_sh;
        f = {h.page, h.addr, h.cmd};
        if (j >= FIELD_SYMS) return 1'b1;
        f_sh = f << j;
        return f_sh[FIELD_SYMS-1];
    endfunction

    function automatic sym_kind_t sym_kind(frame_hdr_t h, int s, int pre);
        if (s < pre) return SYM_RST;
        return sym_value(h, s - pre) ? SYM_ONE : SYM_ZERO;
    endfunction

endpackage

// File: rtl/iso_tick_gen.sv
module iso_tick_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic line_clk,
    output logic sample_stb,
    output logic bit_end
);
    localparam int CW = (2 * DIV_HALF > 2) ? $clog2(2 * DIV_HALF) : 1;
    localparam logic [CW-1:0] MID  = CW'(DIV_HALF);
    localparam logic [CW-1:0] LAST = CW'(2 * DIV_HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign line_clk   = run && (cnt_q >= MID);
    assign sample_stb = run && (cnt_q == MID);
    assign bit_end    = run && (cnt_q == LAST);
endmodule

// File: rtl/iso_status_rx.sv
module iso_status_rx #(
    parameter int PRE_SYMS = 8,
    parameter int SYM_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             line_in,
    input  logic             sample_stb,
    input  logic             bit_end,
    input  logic [3:0]       bit_idx,
    input  logic [SYM_W-1:0] sym_idx,
    output logic [7:0]       acc
);
    localparam int FIRST_SYM = PRE_SYMS + 11;
    localparam int LAST_SYM  = PRE_SYMS + 18;

    logic hit_q;
    logic win_pos, win_sym, hit_now;

    assign win_pos = (bit_idx >= 4'd4) && (bit_idx <= 4'd7);
    assign win_sym = (int'(sym_idx) >= FIRST_SYM) && (int'(sym_idx) <= LAST_SYM);
    assign hit_now = hit_q | (sample_stb & win_pos & line_in);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hit_q <= 1'b0;
            acc   <= '0;
        end else if (bit_end && bit_idx == 4'd15) begin
            hit_q <= 1'b0;
            if (win_sym) acc <= {acc[6:0], hit_now};
        end else begin
            hit_q <= hit_now;
        end
    end
endmodule

// File: rtl/iso_cmd_serializer.sv
module iso_cmd_serializer #(
    parameter int          PRE_SYMS = 8,
    parameter int          DIV_HALF = 2,
    parameter logic [15:0] PAT_RST  = 16'h0000,
    parameter logic [15:0] PAT_ONE  = 16'hFFF0,
    parameter logic [15:0] PAT_ZERO = 16'hF000,
    parameter logic [3:0]  CMD_POLL = 4'h1,
    parameter logic [3:0]  CMD_ON   = 4'h3,
    parameter logic [3:0]  CMD_OFF  = 4'h2,
    parameter logic [2:0]  PAGE_CMD = 3'h0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [2:0] page_i,
    input  logic [3:0] cmd_i,
    input  logic [3:0] dev_addr_i,
    input  logic       line_in_i,
    output logic       line_clk_o,
    output logic       line_out_o,
    output logic       line_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] status_o,
    output logic       out_on_o
);
    import iso_cmd_pkg::*;

    localparam int NSYM  = PRE_SYMS + FIELD_SYMS + FILL_SYMS;
    localparam int SYM_W = $clog2(NSYM);

    function automatic logic [SLOT_W-1:0] pat_of(sym_kind_t k);
        case (k)
            SYM_RST:  return PAT_RST;
            SYM_ZERO: return PAT_ZERO;
            default:  return PAT_ONE;
        endcase
    endfunction

    logic              busy_q, done_q, on_q;
    logic [7:0]        status_q;
    frame_hdr_t        hdr_q, hdr_new;
    logic [SYM_W-1:0]  sym_q;
    logic [3:0]        bitn_q;
    logic [SLOT_W-1:0] shreg_q;

    logic accept, sym_end, frame_end, sample_stb, bit_end, line_clk;
    logic is_poll, is_on, is_off;
    logic [SLOT_W-1:0] first_pat, nxt_pat;
    logic [7:0] rx_acc;

    assign hdr_new   = '{page: page_i, addr: dev_addr_i[2:0], cmd: cmd_i};
    assign accept    = start_i && !busy_q && (dev_addr_i <= 4'd7);
    assign sym_end   = bit_end && (bitn_q == 4'd15);
    assign frame_end = sym_end && (sym_q == SYM_W'(NSYM - 1));
    assign first_pat = pat_of(sym_kind(hdr_new, 0, PRE_SYMS));
    assign nxt_pat   = pat_of(sym_kind(hdr_q, int'(sym_q) + 1, PRE_SYMS));
    assign is_poll   = (hdr_q.page == PAGE_CMD) && (hdr_q.cmd == CMD_POLL);
    assign is_on     = (hdr_q.page == PAGE_CMD) && (hdr_q.cmd == CMD_ON);
    assign is_off    = (hdr_q.page == PAGE_CMD) && (hdr_q.cmd == CMD_OFF);

    iso_tick_gen #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .run        (busy_q),
        .line_clk   (line_clk),
        .sample_stb (sample_stb),
        .bit_end    (bit_end)
    );

    iso_status_rx #(.PRE_SYMS(PRE_SYMS), .SYM_W(SYM_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .line_in    (line_in_i),
        .sample_stb (sample_stb),
        .bit_end    (bit_end),
        .bit_idx    (bitn_q),
        .sym_idx    (sym_q),
        .acc        (rx_acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            on_q     <= 1'b0;
            status_q <= '0;
            hdr_q    <= '0;
            sym_q    <= '0;
            bitn_q   <= '0;
            shreg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                hdr_q   <= hdr_new;
                sym_q   <= '0;
                bitn_q  <= '0;
                shreg_q <= first_pat;
            end else if (busy_q && bit_end) begin
                if (frame_end) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    if (is_poll) status_q <= rx_acc;
                    if (is_on)       on_q <= 1'b1;
                    else if (is_off) on_q <= 1'b0;
                end else if (sym_end) begin
                    bitn_q  <= '0;
                    sym_q   <= sym_q + 1'b1;
                    shreg_q <= nxt_pat;
                end else begin
                    bitn_q  <= bitn_q + 1'b1;
                    shreg_q <= {shreg_q[SLOT_W-2:0], 1'b0};
                end
            end
        end
    end

    assign line_clk_o = line_clk;
    assign line_out_o = busy_q & shreg_q[SLOT_W-1];
    assign line_oe_o  = busy_q;
    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign status_o   = status_q;
    assign out_on_o   = on_q;
endmodule

// File: rtl/iso_cmd_checker.sv
module iso_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [3:0] dev_addr_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       line_clk_o,
    input logic       line_oe_o,
    input logic       line_out_o,
    input logic [7:0] status_o,
    input logic       out_on_o
);
    assert_clk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !line_clk_o);

    assert_quiet_line_R11: assert property (@(posedge clk) disable iff (rst)
        !line_oe_o |-> !line_out_o);

    assert_addr_reject_R4: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && dev_addr_i > 4'd7) |=> !busy_o);

    assert_start_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_status_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(status_o));

    assert_switch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(out_on_o));
endmodule

bind iso_cmd_serializer iso_cmd_checker u_iso_cmd_checker (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .dev_addr_i (dev_addr_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .line_clk_o (line_clk_o),
    .line_oe_o  (line_oe_o),
    .line_out_o (line_out_o),
    .status_o   (status_o),
    .out_on_o   (out_on_o)
);

// File: tb/iso_cmd_serializer_bench.sv
module iso_cmd_serializer_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          PRE        = 8;
    localparam int          HALF       = 2;
    localparam logic [15:0] P_RST      = 16'h0000;
    localparam logic [15:0] P_ONE      = 16'hFFF0;
    localparam logic [15:0] P_ZERO     = 16'hF000;
    localparam int          NSYM       = PRE + 20;
    localparam int          NBITS      = NSYM * 16;
    localparam int          FRAME_CYC  = NBITS * 2 * HALF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [2:0] page_i = '0;
    logic [3:0] cmd_i = '0;
    logic [3:0] dev_addr_i = '0;
    logic line_in_i = 1'b0;
    logic line_clk_o, line_out_o, line_oe_o, busy_o, done_o, out_on_o;
    logic [7:0] status_o;

    int nchk = 0;
    int nbad = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iso_cmd_serializer #(
        .PRE_SYMS(PRE), .DIV_HALF(HALF),
        .PAT_RST(P_RST), .PAT_ONE(P_ONE), .PAT_ZERO(P_ZERO),
        .CMD_POLL(4'h1), .CMD_ON(4'h3), .CMD_OFF(4'h2), .PAGE_CMD(3'h0)
    ) u_iso_cmd_serializer (
        .clk(clk), .rst(rst), .start_i(start_i), .page_i(page_i),
        .cmd_i(cmd_i), .dev_addr_i(dev_addr_i), .line_in_i(line_in_i),
        .line_clk_o(line_clk_o), .line_out_o(line_out_o), .line_oe_o(line_oe_o),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o), .out_on_o(out_on_o)
    );

    // Capture of the outgoing line at each rising line clock
    logic cap [0:1023];
    int capn = 0;
    always @(posedge line_clk_o) begin
        if (capn < 1024) cap[capn] = line_out_o;
        capn++;
    end

    // Device model on the returning line
    logic [7:0] dev_status = 8'h00;
    int dev_var = 0;
    logic dev_noise = 1'b0;
    int ebit = 0;

    function automatic logic dev_val(int e);
        int s, p, k;
        s = e / 16;
        p = e % 16;
        if (p < 4 || p > 7) return 1'b1;
        if (s >= PRE + 11 && s <= PRE + 18) begin
            k = s - PRE - 11;
            return dev_status[3'(7 - k)] && (p == 4 + ((k + dev_var) % 4));
        end
        return dev_noise;
    endfunction

    always @(posedge busy_o) begin
        ebit = 0;
        line_in_i = dev_val(0);
    end
    always @(negedge line_clk_o) begin
        ebit++;
        line_in_i = dev_val(ebit);
    end

    function automatic logic exp_bit(int e, logic [2:0] pg, logic [2:0] ad, logic [3:0] cm);
        int s, p, j;
        logic b;
        logic [15:0] pat;
        s = e / 16;
        p = e % 16;
        if (s < PRE) pat = P_RST;
        else begin
            j = s - PRE;
            if (j < 3)       b = pg[2'(2 - j)];
            else if (j < 6)  b = ad[2'(5 - j)];
            else if (j < 10) b = cm[2'(9 - j)];
            else             b = 1'b1;
            pat = b ? P_ONE : P_ZERO;
        end
        return pat[4'(15 - p)];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic run_frame(input logic [2:0] pg, input logic [3:0] cm, input logic [2:0] ad,
                             input logic [7:0] st, input int vr, input logic nz, input bit mid);
        int cyc, mism, first_bad, guard;
        dev_status = st;
        dev_var = vr;
        dev_noise = nz;
        @(negedge clk);
        page_i = pg; cmd_i = cm; dev_addr_i = {1'b0, ad};
        capn = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        guard = 0;
        if (busy_o) cyc++;
        while (!done_o && guard < 4 * FRAME_CYC) begin
            @(negedge clk);
            guard++;
            if (busy_o) cyc++;
            if (mid && cyc == 100) begin
                start_i = 1'b1; page_i = ~pg; cmd_i = ~cm; dev_addr_i = 4'd0;
            end
            if (mid && cyc == 104) start_i = 1'b0;
        end
        chk(done_o == 1'b1, "R9 done seen", done_o, 1);
        chk(busy_o == 1'b0, "R9 busy low with done", busy_o, 0);
        chk(cyc == FRAME_CYC, "R3 busy length", cyc, FRAME_CYC);
        chk(capn == NBITS, "R2 slot count", capn, NBITS);
        mism = 0;
        first_bad = -1;
        for (int e = 0; e < NBITS; e++) begin
            if (cap[e] !== exp_bit(e, pg, ad, cm)) begin
                mism++;
                if (first_bad < 0) first_bad = e;
            end
        end
        chk(mism == 0, "R1 R2 R3 frame slots (mismatch count vs first bad slot)", mism, first_bad);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        if (mid) begin
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (busy_o) break;
            end
            chk(busy_o == 1'b0, "R8 no queued frame", busy_o, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            nbad++;
            nchk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [7:0] vals [0:8];
        vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h5A; vals[4] = 8'h01;
        vals[5] = 8'h80; vals[6] = 8'h3C; vals[7] = 8'hC3; vals[8] = 8'h96;

        repeat (4) @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && line_clk_o == 0, "R10 control during reset",
            {busy_o, done_o, line_clk_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(status_o == 8'h00 && out_on_o == 0, "R10 outputs after reset", {status_o, out_on_o}, 0);
        chk(line_oe_o == 0 && line_out_o == 0, "R11 idle line", {line_oe_o, line_out_o}, 0);

        // Header sweep: every page, address and command value
        for (int i = 0; i < 16; i++) begin
            run_frame(3'(i % 8), 4'(i), 3'(7 - (i % 8)), 8'hFF, i % 4, 1'b1, 1'b0);
        end
        chk(status_o == 8'h00, "R6 status untouched by non-poll frames", status_o, 0);
        chk(out_on_o == 1'b0, "R7 flag untouched by other frames", out_on_o, 0);

        // Addresses above 7 are refused
        for (int a = 8; a < 16; a++) begin
            @(negedge clk);
            dev_addr_i = 4'(a); page_i = 3'd0; cmd_i = 4'h3;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (4) @(negedge clk);
            chk(busy_o == 1'b0 && done_o == 1'b0, "R4 address refused", busy_o, 0);
        end
        chk(out_on_o == 1'b0, "R4 refused on frame has no effect", out_on_o, 0);

        // Status read-back sweep
        for (int i = 0; i < 9; i++) begin
            run_frame(3'd0, 4'h1, 3'(i % 8), vals[i], i % 4, 1'(i % 2), 1'b0);
            chk(status_o == vals[i], "R5 status byte", status_o, vals[i]);
        end

        // On frame: flag set, status kept
        run_frame(3'd0, 4'h3, 3'd5, 8'h0F, 1, 1'b1, 1'b0);
        chk(out_on_o == 1'b1, "R7 on frame sets flag", out_on_o, 1);
        chk(status_o == vals[8], "R6 on frame keeps status", status_o, vals[8]);

        // Off code on a nonzero page: no effect
        run_frame(3'd5, 4'h2, 3'd2, 8'h00, 2, 1'b0, 1'b0);
        chk(out_on_o == 1'b1, "R7 off code on other page ignored", out_on_o, 1);

        // Poll keeps the flag
        run_frame(3'd0, 4'h1, 3'd3, 8'h42, 3, 1'b1, 1'b0);
        chk(out_on_o == 1'b1, "R7 poll keeps flag", out_on_o, 1);
        chk(status_o == 8'h42, "R6 poll updates status", status_o, 8'h42);

        // Off frame clears the flag
        run_frame(3'd0, 4'h2, 3'd6, 8'h00, 0, 1'b0, 1'b0);
        chk(out_on_o == 1'b0, "R7 off frame clears flag", out_on_o, 0);

        // On code on a nonzero page: no effect
        run_frame(3'd1, 4'h3, 3'd6, 8'h00, 0, 1'b0, 1'b0);
        chk(out_on_o == 1'b0, "R7 on code on other page ignored", out_on_o, 0);

        // Start during a frame is ignored
        run_frame(3'd0, 4'h1, 3'd4, 8'h69, 2, 1'b1, 1'b1);
        chk(status_o == 8'h69, "R8 frame unaffected by mid start", status_o, 8'h69);

        finished = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule